// File: doc/BRIEF.md
# Harvard Memory Bus Access Arbiter

This block sits in front of one memory or peripheral slave shared by three CPU-side buses: a program bus, a data read bus and a data write bus. Five kinds of access can compete for that slave: data write, program write, data read, program read and instruction fetch. When the slave is free, the arbiter picks one of them by a fixed ranking and registers a one-hot grant. It then steers the winner's address, write data and direction onto a single slave port. The grant stays in place until the slave signals ready.

Each requester keeps its request and its address or data stable until its own acknowledge arrives. Transfers that go to different slaves are handled by separate copies of this block and do not interact. Program-bus addresses are 22 bits wide and are widened with zeros to the 32-bit slave address.

Top module: `hbus_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gnt` is all zero and `slv_valid` is low.
- R2: The grant bits are indexed as follows: bit 0 data write, bit 1 program write, bit 2 data read, bit 3 program read, bit 4 fetch. A lower index always wins over a higher one.
- R3: At most one bit of `gnt` is set in any cycle.
- R4: A grant appears in the cycle after a clock edge at which the arbiter was free and the request was high. With no request pending, `gnt` stays zero.
- R5: A grant is held unchanged for as long as `slv_ready` is low, even if higher-ranked requests arrive. It clears in the cycle after `slv_ready` is high, and no new grant is issued in that cycle.
- R6: `slv_valid` is high exactly when a grant is held. `slv_addr` is the granted requester's address, with the 22-bit program-bus addresses zero-extended.
- R7: `slv_write` is high only for data write and program write grants. `slv_wdata` carries that requester's data, and is zero for read grants.
- R8: `ack` equals `gnt` gated by `slv_ready`. `rd_data` passes `slv_rdata` through.
- R9: If an out-of-contract pair is requested together, the higher member wins: data write over program write, and program read over fetch.
- R10: A requester that loses keeps its request and is granted at a later arbitration. Several pending requests are served one after another in ranking order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dw_req | input | 1 | Data write request |
| dw_addr | input | 32 | Data write address |
| dw_wdata | input | 32 | Data write data |
| pw_req | input | 1 | Program write request |
| pw_addr | input | 22 | Program write address |
| pw_wdata | input | 32 | Program write data |
| dr_req | input | 1 | Data read request |
| dr_addr | input | 32 | Data read address |
| pr_req | input | 1 | Program read request |
| pr_addr | input | 22 | Program read address |
| if_req | input | 1 | Instruction fetch request |
| if_addr | input | 22 | Fetch address |
| gnt | output | 5 | One-hot held grant |
| ack | output | 5 | Completion strobe per requester |
| rd_data | output | 32 | Read data returned to requesters |
| slv_valid | output | 1 | Slave access valid |
| slv_write | output | 1 | Slave access is a write |
| slv_addr | output | 32 | Slave address |
| slv_wdata | output | 32 | Slave write data |
| slv_rdata | input | 32 | Slave read data |
| slv_ready | input | 1 | Slave completes the current access |

## Verification
The only internal state is the held grant register. If it is wrong, the fault shows at the ports in the very next cycle. A lost hold shows up as a grant that changes while `slv_ready` is low. A missed clear leaves `slv_valid` high in the bubble cycle. A wrong pick puts the wrong address and direction on the slave port as soon as the grant registers. Each scenario therefore checks the grant, the steered address, the direction and the write data one cycle after arbitration, and checks for the bubble one cycle after completion.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int unsigned NCLS = 5;

  typedef enum logic [2:0] {
    CLS_DWR = 3'd0,
    CLS_PWR = 3'd1,
    CLS_DRD = 3'd2,
    CLS_PRD = 3'd3,
    CLS_FET = 3'd4
  } cls_e;

  localparam logic [NCLS-1:0] WRITE_MASK = 5'b00011;
endpackage

// File: rtl/hbus_prio_pick.sv
module hbus_prio_pick #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  logic [N-1:0] blk;

  assign blk[0] = 1'b0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_lvl
      assign pick[i] = req[i] & ~blk[i];
      if (i < N - 1) begin : g_chain
        assign blk[i+1] = blk[i] | req[i];
      end
    end
  endgenerate
endmodule

// File: rtl/hbus_grant_ctl.sv
module hbus_grant_ctl #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         slv_ready,
  output logic [N-1:0] gnt
);
  logic [N-1:0] pick;
  logic [N-1:0] gnt_q;
  logic [N-1:0] gnt_d;
  logic         gnt_en;

  hbus_prio_pick #(.N(N)) u_pick (
    .req  (req),
    .pick (pick)
  );

  always_comb begin
    gnt_d  = gnt_q;
    gnt_en = 1'b0;
    if (gnt_q == '0) begin
      gnt_d  = pick;
      gnt_en = 1'b1;
    end else if (slv_ready) begin
      gnt_d  = '0;
      gnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
    end else if (gnt_en) begin
      gnt_q <= gnt_d;
    end
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/hbus_port_mux.sv
module hbus_port_mux #(
  parameter int unsigned    N     = 5,
  parameter int unsigned    AW    = 32,
  parameter int unsigned    DW    = 32,
  parameter logic [N-1:0]   WMASK = '0
) (
  input  logic [N-1:0]         gnt,
  input  logic [N-1:0][AW-1:0] addr_in,
  input  logic [N-1:0][DW-1:0] wdata_in,
  output logic                 valid,
  output logic                 write,
  output logic [AW-1:0]        addr,
  output logic [DW-1:0]        wdata
);
  always_comb begin
    addr  = '0;
    wdata = '0;
    for (int i = 0; i < int'(N); i++) begin
      addr = addr | (addr_in[i] & {AW{gnt[i]}});
      if (WMASK[i]) begin
        wdata = wdata | (wdata_in[i] & {DW{gnt[i]}});
      end
    end
  end

  assign valid = |gnt;
  assign write = |(gnt & WMASK);
endmodule

// File: rtl/hbus_arbiter.sv
module hbus_arbiter
  import hbus_pkg::*;
#(
  parameter int unsigned DADDR_W = 32,
  parameter int unsigned PADDR_W = 22,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dw_req,
  input  logic [DADDR_W-1:0]  dw_addr,
  input  logic [DATA_W-1:0]   dw_wdata,
  input  logic                pw_req,
  input  logic [PADDR_W-1:0]  pw_addr,
  input  logic [DATA_W-1:0]   pw_wdata,
  input  logic                dr_req,
  input  logic [DADDR_W-1:0]  dr_addr,
  input  logic                pr_req,
  input  logic [PADDR_W-1:0]  pr_addr,
  input  logic                if_req,
  input  logic [PADDR_W-1:0]  if_addr,
  output logic [NCLS-1:0]     gnt,
  output logic [NCLS-1:0]     ack,
  output logic [DATA_W-1:0]   rd_data,
  output logic                slv_valid,
  output logic                slv_write,
  output logic [DADDR_W-1:0]  slv_addr,
  output logic [DATA_W-1:0]   slv_wdata,
  input  logic [DATA_W-1:0]   slv_rdata,
  input  logic                slv_ready
);
  localparam int unsigned PAD_W = DADDR_W - PADDR_W;

  logic [NCLS-1:0]              req;
  logic [NCLS-1:0][DADDR_W-1:0] addr_arr;
  logic [NCLS-1:0][DATA_W-1:0]  wdata_arr;

  assign req[CLS_DWR] = dw_req;
  assign req[CLS_PWR] = pw_req;
  assign req[CLS_DRD] = dr_req;
  assign req[CLS_PRD] = pr_req;
  assign req[CLS_FET] = if_req;

  // program-bus addresses widen with zeros
  assign addr_arr[CLS_DWR] = dw_addr;
  assign addr_arr[CLS_PWR] = {{PAD_W{1'b0}}, pw_addr};
  assign addr_arr[CLS_DRD] = dr_addr;
  assign addr_arr[CLS_PRD] = {{PAD_W{1'b0}}, pr_addr};
  assign addr_arr[CLS_FET] = {{PAD_W{1'b0}}, if_addr};

  assign wdata_arr[CLS_DWR] = dw_wdata;
  assign wdata_arr[CLS_PWR] = pw_wdata;
  assign wdata_arr[CLS_DRD] = '0;
  assign wdata_arr[CLS_PRD] = '0;
  assign wdata_arr[CLS_FET] = '0;

  hbus_grant_ctl #(.N(NCLS)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .slv_ready (slv_ready),
    .gnt       (gnt)
  );

  hbus_port_mux #(
    .N     (NCLS),
    .AW    (DADDR_W),
    .DW    (DATA_W),
    .WMASK (WRITE_MASK)
  ) u_mux (
    .gnt      (gnt),
    .addr_in  (addr_arr),
    .wdata_in (wdata_arr),
    .valid    (slv_valid),
    .write    (slv_write),
    .addr     (slv_addr),
    .wdata    (slv_wdata)
  );

  assign ack     = gnt & {NCLS{slv_ready}};
  assign rd_data = slv_rdata;
endmodule

// File: rtl/hbus_arbiter_chk.sv
module hbus_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dw_req,
  input logic       pw_req,
  input logic       dr_req,
  input logic       pr_req,
  input logic       if_req,
  input logic [4:0] gnt,
  input logic       slv_valid,
  input logic       slv_write,
  input logic       slv_ready
);
  a_r3_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r5_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != 5'd0 && !slv_ready) |=> $stable(gnt));

  a_r5_bubble_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != 5'd0 && slv_ready) |=> gnt == 5'd0);

  a_r2_data_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == 5'd0 && dw_req) |=> gnt[0]);

  a_r4_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == 5'd0 && !dw_req && !pw_req && !dr_req && !pr_req && !if_req) |=> gnt == 5'd0);

  a_r9_read_over_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == 5'd0 && !dw_req && !pw_req && !dr_req && pr_req && if_req) |=> gnt[3]);

  a_r7_write_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_valid && slv_write) |-> (gnt[0] || gnt[1]));
endmodule

bind hbus_arbiter hbus_arbiter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dw_req    (dw_req),
  .pw_req    (pw_req),
  .dr_req    (dr_req),
  .pr_req    (pr_req),
  .if_req    (if_req),
  .gnt       (gnt),
  .slv_valid (slv_valid),
  .slv_write (slv_write),
  .slv_ready (slv_ready)
);

// File: tb/hbus_arbiter_test.sv
module hbus_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  req;
  logic [31:0] slv_rdata;
  logic        slv_ready;
  logic [4:0]  gnt;
  logic [4:0]  ack;
  logic [31:0] rd_data;
  logic        slv_valid;
  logic        slv_write;
  logic [31:0] slv_addr;
  logic [31:0] slv_wdata;

  int n_chk  = 0;
  int n_fail = 0;

  localparam logic [31:0] A_DW = 32'hD000_1000;
  localparam logic [21:0] A_PW = 22'h2A_5554;
  localparam logic [31:0] A_DR = 32'h8765_4320;
  localparam logic [21:0] A_PR = 22'h3F_FFFC;
  localparam logic [21:0] A_IF = 22'h01_2340;
  localparam logic [31:0] D_DW = 32'h1111_2222;
  localparam logic [31:0] D_PW = 32'h3333_4444;

  always #4 clk = ~clk;

  hbus_arbiter uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .dw_req    (req[0]),
    .dw_addr   (A_DW),
    .dw_wdata  (D_DW),
    .pw_req    (req[1]),
    .pw_addr   (A_PW),
    .pw_wdata  (D_PW),
    .dr_req    (req[2]),
    .dr_addr   (A_DR),
    .pr_req    (req[3]),
    .pr_addr   (A_PR),
    .if_req    (req[4]),
    .if_addr   (A_IF),
    .gnt       (gnt),
    .ack       (ack),
    .rd_data   (rd_data),
    .slv_valid (slv_valid),
    .slv_write (slv_write),
    .slv_addr  (slv_addr),
    .slv_wdata (slv_wdata),
    .slv_rdata (slv_rdata),
    .slv_ready (slv_ready)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(int idx);
    case (idx)
      0:       return A_DW;
      1:       return {10'd0, A_PW};
      2:       return A_DR;
      3:       return {10'd0, A_PR};
      default: return {10'd0, A_IF};
    endcase
  endfunction

  function automatic logic [31:0] exp_wdata(int idx);
    case (idx)
      0:       return D_DW;
      1:       return D_PW;
      default: return 32'd0;
    endcase
  endfunction

  // called at a negedge one cycle after arbitration
  task automatic expect_grant(int idx, string tag);
    check({tag, " R2 gnt"}, {27'd0, gnt}, 32'd1 << idx);
    check({tag, " R6 valid"}, {31'd0, slv_valid}, 32'd1);
    check({tag, " R6 addr"}, slv_addr, exp_addr(idx));
    check({tag, " R7 write"}, {31'd0, slv_write}, (idx < 2) ? 32'd1 : 32'd0);
    check({tag, " R7 wdata"}, slv_wdata, exp_wdata(idx));
  endtask

  task automatic finish_xfer(int idx, string tag);
    slv_ready = 1'b1;
    slv_rdata = 32'hA500_0000 | idx;
    #1;
    check({tag, " R8 ack"}, {27'd0, ack}, 32'd1 << idx);
    check({tag, " R8 rdata"}, rd_data, 32'hA500_0000 | idx);
    @(negedge clk);
    slv_ready = 1'b0;
    req[idx]  = 1'b0;
    #1;
    check({tag, " R5 bubble"}, {31'd0, slv_valid}, 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req = '0;
    slv_ready = 1'b0;
    slv_rdata = '0;
    repeat (3) @(negedge clk);
    check("R1 gnt in reset", {27'd0, gnt}, 32'd0);
    check("R1 valid in reset", {31'd0, slv_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 gnt after reset", {27'd0, gnt}, 32'd0);
  endtask

  task automatic t_idle();
    repeat (3) @(negedge clk);
    check("R4 idle no grant", {27'd0, gnt}, 32'd0);
  endtask

  task automatic t_single(int idx);
    req[idx] = 1'b1;
    #1;
    check("R4 not yet granted", {27'd0, gnt}, 32'd0);
    @(negedge clk);
    expect_grant(idx, "single");
    check("R3 one-hot single", {31'd0, $onehot0(gnt)}, 32'd1);
    finish_xfer(idx, "single");
  endtask

  task automatic t_order(logic [4:0] pat, string tag);
    req = pat;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      if (pat[i]) begin
        expect_grant(i, {tag, " R10"});
        finish_xfer(i, tag);
        @(negedge clk);
      end
    end
    check({tag, " R10 drained"}, {27'd0, gnt}, 32'd0);
  endtask

  task automatic t_hold();
    req[4] = 1'b1;
    @(negedge clk);
    expect_grant(4, "hold");
    req[0] = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R5 held under higher request", {27'd0, gnt}, 32'h10);
    end
    finish_xfer(4, "hold");
    @(negedge clk);
    expect_grant(0, "hold-next");
    finish_xfer(0, "hold-next");
  endtask

  task automatic t_pairs();
    req = 5'b00011;
    @(negedge clk);
    check("R9 data write over program write", {27'd0, gnt}, 32'h01);
    finish_xfer(0, "pair-a");
    @(negedge clk);
    expect_grant(1, "pair-a R10");
    finish_xfer(1, "pair-a");
    req = 5'b11000;
    @(negedge clk);
    check("R9 program read over fetch", {27'd0, gnt}, 32'h08);
    finish_xfer(3, "pair-b");
    @(negedge clk);
    expect_grant(4, "pair-b R10");
    finish_xfer(4, "pair-b");
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog R10 run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    for (int i = 0; i < 5; i++) t_single(i);
    t_order(5'b10101, "order-a");
    t_order(5'b01110, "order-b");
    t_hold();
    t_pairs();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule